// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Control

This block sits between the clock sources of a system clock generator and its output pins. It takes the raw processor, PCI and graphics-port clocks and produces gated copies of each, one per output. Three active-low power-management pins can request a stop: one stops the processor clocks, one stops the four ordinary PCI clocks, and one powers everything down. These pins share package pins with memory clock outputs. They are therefore honoured only while the mode input is low. When mode is high they are ignored.

The stop pins may change at any time. Each request is brought into the clock domain it acts on through a short chain of rising-edge flops. The gate enable of every output is then loaded on the falling edge of its source clock and ANDed with that clock. An output therefore only turns off or on while its source is low, and it never produces a shortened pulse. Every output also has its own enable bit from a configuration register. A cleared bit holds that output low whatever the stop pins do. Once every domain has stopped for power-down, the block raises a request for the oscillator and PLLs to shut off. It drops that request as soon as the power-down pin is released.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_i` is high (synchronous, active high), every gated clock output and `pll_off_o` are low.
- R2: The processor-stop request (mode low and `cpu_stop_n_i` low) is synchronized by two rising edges of the processor clock. If the pin changes in the low phase before rising edge E1, the outputs still pulse at E1 and E2 and change state from E3 onward, for both stop and restart.
- R3: The PCI-stop request (mode low and `pci_stop_n_i` low) is synchronized by one rising edge of the PCI clock. If the pin changes before rising edge E1, the four ordinary PCI outputs still pulse at E1 and change state from E2 onward.
- R4: The processor-stop pin affects only the processor outputs. The PCI-stop pin affects only the four ordinary PCI outputs. The free-running PCI output and the two graphics-port outputs ignore both pins.
- R5: The power-down request (mode low and `pwr_dwn_n_i` low) holds every output low. It follows the latency of each domain: two edges for the processor and graphics-port clocks, one edge for both PCI groups.
- R6: `pll_off_o` goes high once a power-down request is pending and every domain has stopped. It goes low at once, without waiting for a clock, when the request is withdrawn.
- R7: While `mode_i` is high, all three stop pins are ignored and no output is stopped or powered down.
- R8: Each output has an enable bit (1 = run, 0 = held low). The bit is sampled on the falling edge of that output's source clock and takes effect at the next rising edge.
- R9: Every output is low during each low phase of its source clock. Each high phase of an output is a complete high phase of its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Raw processor clock |
| pci_clk_i | input | 1 | Raw PCI clock |
| agp_clk_i | input | 1 | Raw graphics-port clock |
| rst_i | input | 1 | Synchronous active-high reset, held over several cycles of every clock |
| mode_i | input | 1 | Low: the shared pins act as stop inputs; high: they are ignored |
| cpu_stop_n_i | input | 1 | Asynchronous active-low processor clock stop |
| pci_stop_n_i | input | 1 | Asynchronous active-low PCI clock stop |
| pwr_dwn_n_i | input | 1 | Asynchronous active-low power-down |
| cpu_en_i | input | 4 | Per-output enable for the processor clocks |
| pci_en_i | input | 4 | Per-output enable for the ordinary PCI clocks |
| pcif_en_i | input | 1 | Enable for the free-running PCI clock |
| agp_en_i | input | 2 | Per-output enable for the graphics-port clocks |
| cpu_clk_o | output | 4 | Gated processor clocks |
| pci_clk_o | output | 4 | Gated ordinary PCI clocks |
| pcif_clk_o | output | 1 | Free-running PCI clock, gated only by power-down and its enable |
| agp_clk_o | output | 2 | Gated graphics-port clocks |
| pll_off_o | output | 1 | Request to shut down the oscillator and PLLs |

## Verification
A synchronizer with the wrong depth shows up as an output that stops or restarts one rising edge too early or too late after a stop pin changes. The check on the first rising edge after the change catches it. A gate enable loaded on the wrong edge, or a request routed to the wrong domain, shows as a high level during a source low phase, or as a pulse on a clock that should have ignored the pin. Either is seen within one source period. A faulty power-down flag shows as the shut-off request appearing while an output still toggles, or staying high after the pin is released.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Synchronizer depth per clock group; sets each group's stop latency.
    localparam int CPU_SYNC_STAGES = 2;
    localparam int PCI_SYNC_STAGES = 1;
    localparam int AGP_SYNC_STAGES = 2;

    // Output counts per group.
    localparam int N_CPU = 4;
    localparam int N_PCI = 4;
    localparam int N_AGP = 2;

    // Qualified power-management request for one domain (active high).
    typedef struct packed {
        logic stop;
        logic pd;
    } pm_req_t;

    // A shared pin counts as a request only while mode is low.
    function automatic logic pin_asserted(input logic mode, input logic pin_n);
        return (~mode) & (~pin_n);
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [DEPTH-1:0] chain;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[DEPTH-2:0], d};
            end
        end
    endgenerate

    assign q = chain[DEPTH-1];

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] en,
    output logic [W-1:0] gclk
);

    logic [W-1:0] en_q;

    // Enable changes only while the source clock is low.
    always_ff @(negedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en;
    end

    assign gclk = {W{clk}} & en_q;

    generate
        for (genvar i = 0; i < W; i++) begin : g_chk
            // R8
            en_off_chk: assert property (@(negedge clk) disable iff (rst)
                !$past(en[i]) |-> !gclk[i]);
        end
    endgenerate

endmodule

// File: rtl/clkstop_domain.sv
module clkstop_domain
    import clkstop_pkg::*;
#(
    parameter int W          = 4,
    parameter int DEPTH      = 2,
    parameter bit HONOR_STOP = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  pm_req_t      req,
    input  logic [W-1:0] en,
    output logic [W-1:0] gclk,
    output logic         pd_stopped
);

    logic stop_s;
    logic pd_s;
    logic [W-1:0] gate_en;

    clkstop_sync #(.DEPTH(DEPTH)) u_pd_sync (
        .clk (clk),
        .rst (rst),
        .d   (req.pd),
        .q   (pd_s)
    );

    generate
        if (HONOR_STOP) begin : g_stop
            clkstop_sync #(.DEPTH(DEPTH)) u_stop_sync (
                .clk (clk),
                .rst (rst),
                .d   (req.stop),
                .q   (stop_s)
            );
        end else begin : g_nostop
            assign stop_s = 1'b0;
        end
    endgenerate

    assign gate_en = en & ~{W{stop_s | pd_s}};

    clkstop_gate #(.W(W)) u_gate (
        .clk  (clk),
        .rst  (rst),
        .en   (gate_en),
        .gclk (gclk)
    );

    always_ff @(negedge clk) begin
        if (rst) pd_stopped <= 1'b0;
        else     pd_stopped <= pd_s;
    end

    // R2
    stop_hold_chk: assert property (@(negedge clk) disable iff (rst)
        $past(stop_s) |-> (gclk == '0));

    // R5
    pd_hold_chk: assert property (@(negedge clk) disable iff (rst)
        $past(pd_s) |-> (gclk == '0));

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
(
    input  logic             cpu_clk_i,
    input  logic             pci_clk_i,
    input  logic             agp_clk_i,
    input  logic             rst_i,
    input  logic             mode_i,
    input  logic             cpu_stop_n_i,
    input  logic             pci_stop_n_i,
    input  logic             pwr_dwn_n_i,
    input  logic [N_CPU-1:0] cpu_en_i,
    input  logic [N_PCI-1:0] pci_en_i,
    input  logic             pcif_en_i,
    input  logic [N_AGP-1:0] agp_en_i,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pcif_clk_o,
    output logic [N_AGP-1:0] agp_clk_o,
    output logic             pll_off_o
);

    logic    pd_raw;
    pm_req_t cpu_req, pci_req, free_req;
    logic    cpu_pdf, pci_pdf, pcif_pdf, agp_pdf;
    logic [0:0] pcif_en_v, pcif_clk_v;

    assign pd_raw        = pin_asserted(mode_i, pwr_dwn_n_i);
    assign cpu_req.stop  = pin_asserted(mode_i, cpu_stop_n_i);
    assign cpu_req.pd    = pd_raw;
    assign pci_req.stop  = pin_asserted(mode_i, pci_stop_n_i);
    assign pci_req.pd    = pd_raw;
    assign free_req.stop = 1'b0;
    assign free_req.pd   = pd_raw;
    assign pcif_en_v     = pcif_en_i;
    assign pcif_clk_o    = pcif_clk_v[0];

    clkstop_domain #(.W(N_CPU), .DEPTH(CPU_SYNC_STAGES), .HONOR_STOP(1'b1)) u_cpu (
        .clk (cpu_clk_i), .rst (rst_i), .req (cpu_req), .en (cpu_en_i),
        .gclk (cpu_clk_o), .pd_stopped (cpu_pdf)
    );

    clkstop_domain #(.W(N_PCI), .DEPTH(PCI_SYNC_STAGES), .HONOR_STOP(1'b1)) u_pci (
        .clk (pci_clk_i), .rst (rst_i), .req (pci_req), .en (pci_en_i),
        .gclk (pci_clk_o), .pd_stopped (pci_pdf)
    );

    clkstop_domain #(.W(1), .DEPTH(PCI_SYNC_STAGES), .HONOR_STOP(1'b0)) u_pcif (
        .clk (pci_clk_i), .rst (rst_i), .req (free_req), .en (pcif_en_v),
        .gclk (pcif_clk_v), .pd_stopped (pcif_pdf)
    );

    clkstop_domain #(.W(N_AGP), .DEPTH(AGP_SYNC_STAGES), .HONOR_STOP(1'b0)) u_agp (
        .clk (agp_clk_i), .rst (rst_i), .req (free_req), .en (agp_en_i),
        .gclk (agp_clk_o), .pd_stopped (agp_pdf)
    );

    // Withdrawal of the pin releases the request without waiting for a clock.
    assign pll_off_o = pd_raw & cpu_pdf & pci_pdf & pcif_pdf & agp_pdf;

    // R6
    pll_off_chk: assert property (@(negedge cpu_clk_i) disable iff (rst_i)
        pll_off_o |-> (cpu_clk_o == '0 && pci_clk_o == '0 && !pcif_clk_o && agp_clk_o == '0));

endmodule

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/100ps

module tb_clk_mon #(
    parameter int    W     = 1,
    parameter int    DEPTH = 1,
    parameter string TAG   = "R0"
) (
    input logic         clk,
    input logic         rst,
    input logic         req,
    input logic [W-1:0] en,
    input logic [W-1:0] gclk
);
    int checks = 0;
    int fails  = 0;
    logic [W-1:0] en_prev = '0;
    logic [2:0]   hist    = '0;

    function automatic logic [W-1:0] expect_out(input logic [2:0] h, input logic [W-1:0] e);
        return h[DEPTH] ? '0 : e;
    endfunction

    always @(posedge clk) begin
        logic [W-1:0] exp_v;
        hist  = {hist[1:0], req};
        exp_v = expect_out(hist, en_prev);
        #1;
        if (!rst) begin
            checks++;
            if (gclk !== exp_v) begin
                fails++;
                $display("FAIL %s high phase t=%0t actual=%b expected=%b", TAG, $time, gclk, exp_v);
            end
        end
    end

    always @(negedge clk) begin
        en_prev = rst ? '0 : en;
        #1;
        if (!rst) begin
            checks++;
            if (gclk !== '0) begin
                fails++;
                $display("FAIL R9 %s low phase t=%0t actual=%b expected=0", TAG, $time, gclk);
            end
        end
    end
endmodule

module tb_clkstop_ctrl;
    logic cpu_clk = 0, pci_clk = 0, agp_clk = 0;
    logic rst = 1, mode = 0;
    logic cpu_stop_n = 1, pci_stop_n = 1, pwr_dwn_n = 1;
    logic [3:0] cpu_en = 4'hF, pci_en = 4'hF;
    logic       pcif_en = 1;
    logic [1:0] agp_en = 2'h3;
    logic [3:0] cpu_clk_o, pci_clk_o;
    logic       pcif_clk_o, pll_off_o;
    logic [1:0] agp_clk_o;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4  cpu_clk = ~cpu_clk;
    always #10 pci_clk = ~pci_clk;
    always #6  agp_clk = ~agp_clk;

    clkstop_ctrl dut (
        .cpu_clk_i (cpu_clk), .pci_clk_i (pci_clk), .agp_clk_i (agp_clk),
        .rst_i (rst), .mode_i (mode),
        .cpu_stop_n_i (cpu_stop_n), .pci_stop_n_i (pci_stop_n), .pwr_dwn_n_i (pwr_dwn_n),
        .cpu_en_i (cpu_en), .pci_en_i (pci_en), .pcif_en_i (pcif_en), .agp_en_i (agp_en),
        .cpu_clk_o (cpu_clk_o), .pci_clk_o (pci_clk_o), .pcif_clk_o (pcif_clk_o),
        .agp_clk_o (agp_clk_o), .pll_off_o (pll_off_o)
    );

    // Expected request per group, from R2..R5 and R7.
    function automatic logic req_of(input logic m, input logic stop_n, input logic pd_n);
        return !m && (!stop_n || !pd_n);
    endfunction

    logic cpu_req_e, pci_req_e, free_req_e;
    assign cpu_req_e  = req_of(mode, cpu_stop_n, pwr_dwn_n);
    assign pci_req_e  = req_of(mode, pci_stop_n, pwr_dwn_n);
    assign free_req_e = req_of(mode, 1'b1, pwr_dwn_n);

    tb_clk_mon #(.W(4), .DEPTH(2), .TAG("R2")) m_cpu (.clk(cpu_clk), .rst(rst), .req(cpu_req_e), .en(cpu_en), .gclk(cpu_clk_o));
    tb_clk_mon #(.W(4), .DEPTH(1), .TAG("R3")) m_pci (.clk(pci_clk), .rst(rst), .req(pci_req_e), .en(pci_en), .gclk(pci_clk_o));
    tb_clk_mon #(.W(1), .DEPTH(1), .TAG("R4")) m_pcif (.clk(pci_clk), .rst(rst), .req(free_req_e), .en(pcif_en), .gclk(pcif_clk_o));
    tb_clk_mon #(.W(2), .DEPTH(2), .TAG("R5")) m_agp (.clk(agp_clk), .rst(rst), .req(free_req_e), .en(agp_en), .gclk(agp_clk_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp_v);
        end
    endtask

    // Return to a x.3 ns point so that no stimulus meets a clock edge.
    task automatic realign();
        @(posedge cpu_clk);
        #0.3;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            checks += m_cpu.checks + m_pci.checks + m_pcif.checks + m_agp.checks;
            fails  += m_cpu.fails + m_pci.fails + m_pcif.fails + m_agp.fails;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd1234);
        // R1: outputs low during reset
        #100.3;
        check("R1", {cpu_clk_o, pci_clk_o, pcif_clk_o, agp_clk_o, pll_off_o}, '0);
        #17;
        check("R1", {cpu_clk_o, pci_clk_o, pcif_clk_o, agp_clk_o, pll_off_o}, '0);
        rst = 0;
        #200;

        // R8: one disabled output stays low while its neighbour runs
        cpu_en = 4'b1110;
        repeat (4) @(posedge cpu_clk);
        repeat (5) begin
            @(posedge cpu_clk); #1;
            check("R8", {30'd0, cpu_clk_o[1:0]}, 32'd2);
        end
        cpu_en = 4'hF;
        realign();

        // R7: mode high makes every stop pin ineffective
        mode = 1; cpu_stop_n = 0; pci_stop_n = 0; pwr_dwn_n = 0;
        repeat (6) @(posedge cpu_clk);
        #1;
        check("R7", {28'd0, cpu_clk_o}, 32'hF);
        check("R7", {31'd0, pll_off_o}, 32'd0);
        realign();
        cpu_stop_n = 1; pci_stop_n = 1; pwr_dwn_n = 1;
        #100;
        mode = 0;
        #100;

        // R6: power-down raises the shut-off request; release drops it at once
        pwr_dwn_n = 0;
        #200;
        check("R6", {31'd0, pll_off_o}, 32'd1);
        check("R5", {cpu_clk_o, pci_clk_o, pcif_clk_o, agp_clk_o}, '0);
        pwr_dwn_n = 1;
        #1;
        check("R6", {31'd0, pll_off_o}, 32'd0);
        realign();
        #100;

        // Random stimulus; the monitors check every edge.
        for (int i = 0; i < 600; i++) begin
            #($urandom_range(40, 3));
            case ($urandom_range(9, 0))
                0, 1, 2: cpu_stop_n = ~cpu_stop_n;
                3, 4, 5: pci_stop_n = ~pci_stop_n;
                6:       pwr_dwn_n  = ~pwr_dwn_n;
                7:       mode       = ($urandom_range(3, 0) == 0);
                8:       cpu_en     = 4'($urandom | $urandom);
                default: begin
                    pci_en  = 4'($urandom | $urandom);
                    pcif_en = ($urandom_range(3, 0) != 0);
                    agp_en  = 2'($urandom | $urandom);
                end
            endcase
        end
        #300;
        report();
    end
endmodule